// File: doc/BRIEF.md
# Bus Quiet-Time and Transmit-Permit Timer

This block watches the receive line of a shared serial bus and measures how long the line has stayed quiet. Quiet time is counted in bit times: an external divider supplies one `bit_tick` pulse per bit at the slow rate. When the line has been quiet long enough, the block reports the bus as idle. After a second, longer wait it emits a one-clock transmit-permit strobe. The serializer uses that strobe as the earliest moment at which it may start a frame.

Each node on the bus is given its own permit length. A node with a shorter permit length reaches its permit point first, so it has the higher priority. The gaps between the permit lengths of different nodes must be large enough that two nodes never start together.

In break-sync mode, a node can miss its permit point because it had nothing to send at that moment. That node then waits until the quiet time exceeds a maximum idle length. It then asks the serializer for a break character, which pulls the bus out of idle so that every node can resynchronise.

Top module: `bus_quiet_timer`

## Requirements
- R1: In reset, and on the first cycle after reset, `bus_idle`, `tx_permit` and `send_break` are all low. The quiet count starts at zero.
- R2: Whenever `rx` is sampled low at a clock edge, the quiet count is cleared at that edge. A falling edge therefore restarts the count. If `idle_wait_len` is non-zero, `bus_idle` is low in the cycle that follows.
- R3: While `rx` is high, each `bit_tick` sampled high at an edge adds one to the quiet count. `bus_idle` is high exactly when the count is greater than or equal to `idle_wait_len`.
- R4: `tx_permit` pulses high for one clock in the cycle after the edge at which the count steps to `permit_len`. It pulses once per quiet period. A `permit_len` of 0 never produces a strobe.
- R5: The quiet count saturates at its all-ones value (1023 with default parameters) and never wraps. `bus_idle` therefore stays high through arbitrarily long quiet periods.
- R6: With `brk_sync_en` high, `send_break` pulses for one clock when all of the following hold: `rx` is high, `tx_pending` is high, the count is strictly greater than `max_idle_len`, and `tx_pending` was low at this quiet period's permit strobe. The pulse appears in the cycle after the edge at which these conditions are seen.
- R7: If `tx_pending` is high at the edge that raises the permit strobe, no break is requested for the rest of that quiet period.
- R8: At most one break request is made per quiet period. Sampling `rx` low re-arms the request.
- R9: With `brk_sync_en` low, `send_break` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx | input | 1 | Received bus line; high means the line is quiet |
| bit_tick | input | 1 | One-clock pulse per low-rate bit time |
| tx_pending | input | 1 | A frame is waiting to be sent |
| brk_sync_en | input | 1 | Enables break-sync mode |
| idle_wait_len | input | WAIT_W (8) | Quiet bit times before the bus counts as idle |
| permit_len | input | LEN_W (10) | Quiet bit times before the permit strobe |
| max_idle_len | input | LEN_W (10) | Quiet-time limit after which a break is requested (break-sync mode only) |
| bus_idle | output | 1 | The bus is idle |
| tx_permit | output | 1 | One-clock transmit-permit strobe |
| send_break | output | 1 | One-clock request for a break character |

## Verification
The bench targets four kinds of faulty design.
- A frame pending at the permit point must suppress the break. A design that ignores this would emit a stray break in the middle of a priority slot.
- A node that misses its slot must get exactly one break once the count passes the limit. A design that lacks the one-shot latch would repeat the break on every cycle.
- Holding the line quiet for more than a thousand bit times exposes a counter that wraps: `bus_idle` would drop with no bus activity at all.
- Short low pulses on `rx` in the middle of the count, and a change of permit length, show whether the count restarts and whether the permit strobe moves with the setting.

// File: rtl/bus_quiet_timer.sv
module bus_quiet_timer #(
  parameter int WAIT_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic              bit_tick,
  input  logic              tx_pending,
  input  logic              brk_sync_en,
  input  logic [WAIT_W-1:0] idle_wait_len,
  input  logic [LEN_W-1:0]  permit_len,
  input  logic [LEN_W-1:0]  max_idle_len,
  output logic              bus_idle,
  output logic              tx_permit,
  output logic              send_break
);
  localparam int CNT_W = (LEN_W > WAIT_W) ? LEN_W : WAIT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] quiet_cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             missed;
  logic             brk_done;
  logic             step;
  logic             hit_permit;
  logic             brk_req;

  assign step       = rx && bit_tick && (quiet_cnt != CNT_MAX);
  assign cnt_nxt    = !rx ? '0 : (step ? quiet_cnt + CNT_ONE : quiet_cnt);
  assign hit_permit = step && ((quiet_cnt + CNT_ONE) == CNT_W'(permit_len));
  assign brk_req    = brk_sync_en && rx && tx_pending && missed && !brk_done &&
                      (quiet_cnt > CNT_W'(max_idle_len));
  assign bus_idle   = quiet_cnt >= CNT_W'(idle_wait_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt  <= '0;
      tx_permit  <= 1'b0;
      send_break <= 1'b0;
      missed     <= 1'b0;
      brk_done   <= 1'b0;
    end else begin
      quiet_cnt  <= cnt_nxt;
      tx_permit  <= hit_permit;
      send_break <= brk_req;
      if (!rx) begin
        missed   <= 1'b0;
        brk_done <= 1'b0;
      end else begin
        if (hit_permit && !tx_pending) missed <= 1'b1;
        if (brk_req) brk_done <= 1'b1;
      end
    end
  end

  p_rx_low_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx && idle_wait_len != '0) |=> !bus_idle);

  p_permit_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |=> !tx_permit);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt == CNT_MAX && rx) |=> quiet_cnt == CNT_MAX);

  p_break_past_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> $past(quiet_cnt) > CNT_W'($past(max_idle_len)));

  p_break_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |=> !send_break);

  p_no_break_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_sync_en |=> !send_break);
endmodule

// File: tb/bus_quiet_timer_test.sv
module bus_quiet_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, bit_tick = 1'b0, tx_pending = 1'b0, brk_sync_en = 1'b0;
  logic [7:0] idle_wait_len = 8'd10;
  logic [9:0] permit_len = 10'd20, max_idle_len = 10'd40;
  logic bus_idle, tx_permit, send_break;
  logic tick_on = 1'b0;
  int checks = 0, errors = 0, n_perm = 0, n_brk = 0;
  bit finished = 0;

  typedef struct packed { logic idle; logic perm; logic brk; } exp_t;
  exp_t sbq[$];

  int m_cnt = 0;
  logic m_missed = 0, m_done = 0;

  bus_quiet_timer uut (.clk, .rst_n, .rx, .bit_tick, .tx_pending, .brk_sync_en,
    .idle_wait_len, .permit_len, .max_idle_len, .bus_idle, .tx_permit, .send_break);

  always #2.5 clk = ~clk;

  always @(negedge clk) bit_tick <= tick_on ? ~bit_tick : 1'b0;

  // expected outputs derived from R2..R9, pushed after each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_missed = 0; m_done = 0;
    end else begin
      int pre;
      exp_t e;
      pre = m_cnt;
      e.perm = rx && bit_tick && pre != 1023 && (pre + 1) == int'(permit_len);
      e.brk = brk_sync_en && rx && tx_pending && m_missed && !m_done && pre > int'(max_idle_len);
      if (!rx) m_cnt = 0; else if (bit_tick && pre != 1023) m_cnt = pre + 1;
      if (!rx) begin m_missed = 0; m_done = 0; end
      else begin
        if (e.perm && !tx_pending) m_missed = 1;
        if (e.brk) m_done = 1;
      end
      e.idle = m_cnt >= int'(idle_wait_len);
      sbq.push_back(e);
    end
  end

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(bus_idle, e.idle, "R3 bus_idle");
      check(tx_permit, e.perm, "R4 tx_permit");
      check(send_break, e.brk, "R6 send_break");
      if (tx_permit) n_perm++;
      if (send_break) n_brk++;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic rx_pulse(input int cyc);
    @(negedge clk); rx = 1'b0;
    repeat (cyc) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_idle, 1'b0, "R1 idle in reset");
    check(tx_permit, 1'b0, "R1 permit in reset");
    check(send_break, 1'b0, "R1 break in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_idle | tx_permit | send_break, 1'b0, "R1 after reset");
    tick_on = 1'b1;

    // frame pending before permit point: strobe, no break (R4, R7)
    brk_sync_en = 1'b1; tx_pending = 1'b1;
    n_perm = 0; n_brk = 0;
    wait_ticks(60);
    check_int(n_perm, 1, "R4 one strobe per quiet period");
    check_int(n_brk, 0, "R7 pending at permit suppresses break");
    rx_pulse(3);
    @(negedge clk);
    check(bus_idle, 1'b0, "R2 rx low clears idle");

    // restart in mid-count (R2)
    wait_ticks(8); rx_pulse(1); wait_ticks(8); rx_pulse(2);

    // slot missed, pending late: exactly one break (R6, R8)
    tx_pending = 1'b0; n_perm = 0; n_brk = 0;
    wait_ticks(30); tx_pending = 1'b1;
    wait_ticks(40);
    check_int(n_brk, 1, "R6 break after limit");
    wait_ticks(20);
    check_int(n_brk, 1, "R8 single break per period");
    rx_pulse(4);

    // re-armed after rx low (R8)
    tx_pending = 1'b0; n_brk = 0;
    wait_ticks(25); tx_pending = 1'b1; wait_ticks(40);
    check_int(n_brk, 1, "R8 re-armed after rx low");
    rx_pulse(2);

    // mode off: no break (R9)
    brk_sync_en = 1'b0; tx_pending = 1'b0; n_brk = 0;
    wait_ticks(25); tx_pending = 1'b1; wait_ticks(40);
    check_int(n_brk, 0, "R9 no break with mode off");
    rx_pulse(2);

    // shorter permit length: earlier strobe (R4)
    permit_len = 10'd5; n_perm = 0;
    wait_ticks(6);
    check_int(n_perm, 1, "R4 strobe at short permit length");
    rx_pulse(2);
    permit_len = 10'd0; n_perm = 0;
    wait_ticks(30);
    check_int(n_perm, 0, "R4 zero permit length never strobes");
    rx_pulse(2);

    // saturation (R5)
    permit_len = 10'd20; max_idle_len = 10'd1023; brk_sync_en = 1'b1;
    tx_pending = 1'b0; n_brk = 0;
    wait_ticks(25); tx_pending = 1'b1;
    wait_ticks(1100);
    check(bus_idle, 1'b1, "R5 idle holds past count limit");
    check_int(n_brk, 0, "R5 saturated count never exceeds 1023");
    rx_pulse(2);
    @(negedge clk);
    check(bus_idle, 1'b0, "R2 idle clears after saturation");
    tick_on = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule